// File: doc/BRIEF.md
# Write-Back Write-Allocate Line Cache Controller

This block is a direct-mapped data cache controller placed between a processor load/store port and a word-addressed main memory port. Each cache line holds several words and carries its own tag, a valid flag and a modified ("dirty") flag. Loads that hit return the word straight from the line store. Stores that hit update the line only and mark it modified; main memory sees the change only when that line is later displaced.

On a miss the controller first copies a modified victim line back to memory word by word. It then reads the whole new line in from memory and re-runs the tag compare, which now hits. Stores that miss are handled the same way, so the store word is merged into a complete, freshly fetched line. A later write-back of that line therefore never carries stale words in the positions the store did not touch. The processor holds its request until a one-cycle ready pulse. Memory transfers are one word at a time, each closed by an acknowledge.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset no line is valid and `cpu_ready` and `mem_req` are low. The first access to any line misses and performs four memory reads and no memory write.
- R2: A load that hits completes with `cpu_ready` high in the first cycle after the request is accepted. `cpu_rdata` carries the cached word, and no memory transfer is made.
- R3: A load miss on an invalid or clean line reads the four words of the line from memory at word addresses {tag, index, 0..3}, in ascending order. It then returns the requested word. The processor word address splits as offset in bits [1:0], index in bits [5:2] and tag in bits [11:6].
- R4: A store that hits completes in the first cycle after acceptance and updates only the addressed word. It makes no memory transfer, so main memory keeps its old value until eviction.
- R5: A store that misses first fetches the full line and then merges the store word. Afterwards every other word of the line reads back the memory value, and a later eviction writes those values back unchanged.
- R6: A miss whose victim line is valid and modified first writes the four victim words to memory, offsets 0..3 in order under the victim's tag. Only then is the new line read.
- R7: A miss whose victim is valid but unmodified performs no memory write.
- R8: `cpu_ready` is never high while `mem_req` is high.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 12 | Processor word address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current word transfer |

## Verification
Two actions meet in one clock edge: the last fill word lands in the line store on the same edge that installs the new tag and clears the modified flag. The merge of a missed store then follows in the next compare. To provoke this, the bench issues a store miss to offset 3, so that the store word and the final fill word share a position, and it adds memory latency. The result is judged by reading back all four words and by forcing an eviction, then comparing the written-back words against a reference memory kept in the bench.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
// Shared types for the line cache controller.
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_COMPARE   = 2'd1,
        ST_WRITEBACK = 2'd2,
        ST_FILL      = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/cache_tag_store.sv
`timescale 1ns/1ps
// Per-line tag, valid and modified flags.
// Assumes one line index per cycle; install and set_mod are never both
// needed on the same line in the same cycle (install wins).
module cache_tag_store #(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    input  logic               install,
    input  logic [TAG_W-1:0]   install_tag,
    input  logic               set_mod,
    output logic [TAG_W-1:0]   rd_tag,
    output logic               rd_valid,
    output logic               rd_mod
);
    localparam int LINES = 1 << INDEX_W;

    logic [TAG_W-1:0] tags_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] mod_q;

    // Tag array: written only when a fill completes.
    always_ff @(posedge clk) begin
        if (install) tags_q[idx] <= install_tag;
    end

    // Flags: cleared by reset, valid/clean on install, modified on store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            mod_q   <= '0;
        end else if (install) begin
            valid_q[idx] <= 1'b1;
            mod_q[idx]   <= 1'b0;
        end else if (set_mod) begin
            mod_q[idx] <= 1'b1;
        end
    end

    assign rd_tag   = tags_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_mod   = mod_q[idx];

    // R5: a store is only ever merged into a line already resident
    a_r5_store_into_valid: assert property (@(posedge clk) disable iff (!rst_n)
        set_mod |-> valid_q[idx]);
endmodule

// File: rtl/cache_data_store.sv
`timescale 1ns/1ps
// Line data array, one write port and one asynchronous read port.
// Assumes contents are meaningless until the owning line is installed.
module cache_data_store #(
    parameter int INDEX_W  = 4,
    parameter int OFFSET_W = 2,
    parameter int DATA_W   = 32
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [INDEX_W+OFFSET_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [INDEX_W+OFFSET_W-1:0] rd_addr,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int ENTRIES = 1 << (INDEX_W + OFFSET_W);

    logic [DATA_W-1:0] words_q [ENTRIES];

    // Word write from fill or store merge.
    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_addr] <= wr_data;
    end

    assign rd_data = words_q[rd_addr];
endmodule

// File: rtl/cache_fsm.sv
`timescale 1ns/1ps
// Sequencer: latches the processor request, compares tags, and runs
// the victim write-back and line fill one word per memory acknowledge.
// Assumes the processor holds its request until cpu_ready.
module cache_fsm
    import cache_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int INDEX_W  = 4,
    parameter int OFFSET_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic                        cpu_ready,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic                        mem_ack,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic [INDEX_W-1:0]          line_idx,
    output logic                        tag_install,
    output logic [ADDR_W-INDEX_W-OFFSET_W-1:0] new_tag,
    output logic                        tag_set_mod,
    input  logic [ADDR_W-INDEX_W-OFFSET_W-1:0] cur_tag,
    input  logic                        cur_valid,
    input  logic                        cur_mod,
    output logic                        dat_wr_en,
    output logic [INDEX_W+OFFSET_W-1:0] dat_wr_addr,
    output logic [DATA_W-1:0]           dat_wr_data,
    output logic [INDEX_W+OFFSET_W-1:0] dat_rd_addr
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
    localparam logic [OFFSET_W-1:0] LAST_BEAT = '1;

    ctl_state_t          state_q;
    logic                req_we_q;
    logic [ADDR_W-1:0]   req_addr_q;
    logic [DATA_W-1:0]   req_wdata_q;
    logic [OFFSET_W-1:0] beat_q;

    logic [OFFSET_W-1:0] req_off;
    logic                hit;

    assign line_idx = req_addr_q[OFFSET_W +: INDEX_W];
    assign req_off  = req_addr_q[OFFSET_W-1:0];
    assign new_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
    assign hit      = (state_q == ST_COMPARE) && cur_valid && (cur_tag == new_tag);

    // Output and array controls decoded from the current state.
    always_comb begin
        cpu_ready   = hit;
        mem_req     = (state_q == ST_WRITEBACK) || (state_q == ST_FILL);
        mem_we      = (state_q == ST_WRITEBACK);
        mem_addr    = (state_q == ST_WRITEBACK) ? {cur_tag, line_idx, beat_q}
                                                : {new_tag, line_idx, beat_q};
        dat_rd_addr = (state_q == ST_WRITEBACK) ? {line_idx, beat_q}
                                                : {line_idx, req_off};
        tag_install = (state_q == ST_FILL) && mem_ack && (beat_q == LAST_BEAT);
        tag_set_mod = hit && req_we_q;
        dat_wr_en   = tag_set_mod || ((state_q == ST_FILL) && mem_ack);
        if (state_q == ST_FILL) begin
            dat_wr_addr = {line_idx, beat_q};
            dat_wr_data = mem_rdata;
        end else begin
            dat_wr_addr = {line_idx, req_off};
            dat_wr_data = req_wdata_q;
        end
    end

    // Request latch: captured when a new request is taken in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
        end else if (state_q == ST_IDLE && cpu_req) begin
            req_we_q    <= cpu_we;
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
        end
    end

    // State and word counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE:
                    if (cpu_req) state_q <= ST_COMPARE;
                ST_COMPARE: begin
                    beat_q <= '0;
                    if (hit)                        state_q <= ST_IDLE;
                    else if (cur_valid && cur_mod)  state_q <= ST_WRITEBACK;
                    else                            state_q <= ST_FILL;
                end
                ST_WRITEBACK:
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) state_q <= ST_FILL;
                    end
                default:
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) state_q <= ST_COMPARE;
                    end
            endcase
        end
    end

    // R8: processor never completes while memory is busy
    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R9: memory request held steady until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: a write-back always targets a line other than the one requested
    a_r6_victim_differs: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[ADDR_W-1 -: TAG_W] != new_tag));

    // R7: a miss on a clean or empty line goes straight to reading
    a_r7_clean_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && !hit && !(cur_valid && cur_mod))
        |=> (mem_req && !mem_we));

    // R2: completion is only signalled from the compare step
    a_r2_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
endmodule

// File: rtl/wb_cache_ctrl.sv
`timescale 1ns/1ps
// Top: direct-mapped write-back, write-allocate cache controller.
// Assumes a word-addressed memory with a one-word request/acknowledge
// handshake and a processor that holds its request until cpu_ready.
module wb_cache_ctrl #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int INDEX_W  = 4,
    parameter int OFFSET_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
    localparam int LOC_W = INDEX_W + OFFSET_W;

    logic [INDEX_W-1:0] line_idx;
    logic               tag_install, tag_set_mod;
    logic [TAG_W-1:0]   new_tag, cur_tag;
    logic               cur_valid, cur_mod;
    logic               dat_wr_en;
    logic [LOC_W-1:0]   dat_wr_addr, dat_rd_addr;
    logic [DATA_W-1:0]  dat_wr_data, dat_rd_data;

    cache_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .line_idx(line_idx), .tag_install(tag_install), .new_tag(new_tag),
        .tag_set_mod(tag_set_mod), .cur_tag(cur_tag), .cur_valid(cur_valid),
        .cur_mod(cur_mod), .dat_wr_en(dat_wr_en), .dat_wr_addr(dat_wr_addr),
        .dat_wr_data(dat_wr_data), .dat_rd_addr(dat_rd_addr)
    );

    cache_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(line_idx),
        .install(tag_install), .install_tag(new_tag), .set_mod(tag_set_mod),
        .rd_tag(cur_tag), .rd_valid(cur_valid), .rd_mod(cur_mod)
    );

    cache_data_store #(.INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .wr_en(dat_wr_en), .wr_addr(dat_wr_addr), .wr_data(dat_wr_data),
        .rd_addr(dat_rd_addr), .rd_data(dat_rd_data)
    );

    assign cpu_rdata = dat_rd_data;
    assign mem_wdata = dat_rd_data;
endmodule

// File: tb/wb_cache_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module wb_cache_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #4 clk = ~clk;

    wb_cache_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    int checks = 0, failures = 0;
    logic [31:0] bmem [0:4095];
    logic [31:0] gold [0:4095];
    int mem_lat = 0, wait_cnt = 0;
    int ev_n = 0;
    logic        ev_we [0:15];
    logic [11:0] ev_a  [0:15];
    logic [31:0] ev_d  [0:15];
    int r8_viol = 0, r9_viol = 0;

    initial begin
        for (int i = 0; i < 4096; i++) begin
            bmem[i] = 32'h5A000000 ^ (i * 32'h00010003);
            gold[i] = bmem[i];
        end
    end

    // Memory model with adjustable latency and a transfer log.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (wait_cnt < mem_lat) wait_cnt <= wait_cnt + 1;
            else begin
                wait_cnt <= 0;
                mem_ack  <= 1'b1;
                if (ev_n < 16) begin
                    ev_we[ev_n] = mem_we;
                    ev_a[ev_n]  = mem_addr;
                    ev_d[ev_n]  = mem_wdata;
                end
                ev_n = ev_n + 1;
                if (mem_we) bmem[mem_addr] <= mem_wdata;
                else        mem_rdata <= bmem[mem_addr];
            end
        end
    end

    // Port monitors for R8 and R9.
    logic        p_pend = 1'b0, p_we = 1'b0;
    logic [11:0] p_addr = '0;
    logic [31:0] p_wd = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_ready && mem_req) r8_viol++;
            if (p_pend && (!mem_req || mem_addr != p_addr || mem_we != p_we ||
                           (p_we && mem_wdata != p_wd))) r9_viol++;
        end
        p_pend = rst_n && mem_req && !mem_ack;
        p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cpu_op(input bit we, input logic [11:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        if (we) gold[a] = wd;
    endtask

    localparam logic [11:0] A = 12'd332;  // tag 5, index 3
    localparam logic [11:0] B = 12'd460;  // tag 7, index 3
    localparam logic [11:0] C = 12'd588;  // tag 9, index 3
    localparam logic [11:0] D = 12'd152;  // tag 2, index 6
    localparam logic [11:0] E = 12'd728;  // tag 11, index 6

    task automatic t_reset;
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R1 ready after reset", 32'(cpu_ready), 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic t_cold_read;
        logic [31:0] rd; int lat;
        ev_n = 0;
        cpu_op(1'b0, A + 12'd2, '0, rd, lat);
        chk(rd == gold[A+2], "R3 cold read data", rd, gold[A+2]);
        chk(ev_n == 4, "R1 cold read transfer count", ev_n, 4);
        for (int k = 0; k < 4; k++)
            chk(!ev_we[k] && ev_a[k] == A + 12'(k), "R3 fill order", 32'(ev_a[k]), 32'(A + 12'(k)));
    endtask

    task automatic t_read_hit;
        logic [31:0] rd; int lat;
        ev_n = 0;
        cpu_op(1'b0, A + 12'd1, '0, rd, lat);
        chk(rd == gold[A+1], "R2 hit data", rd, gold[A+1]);
        chk(lat == 1, "R2 hit latency", lat, 1);
        chk(ev_n == 0, "R2 no memory traffic", ev_n, 0);
    endtask

    task automatic t_write_hit;
        logic [31:0] rd; int lat;
        logic [31:0] old;
        old = bmem[A+1];
        ev_n = 0;
        cpu_op(1'b1, A + 12'd1, 32'hC0FFEE01, rd, lat);
        chk(lat == 1, "R4 store hit latency", lat, 1);
        chk(ev_n == 0, "R4 store hit no traffic", ev_n, 0);
        chk(bmem[A+1] == old, "R4 memory untouched", bmem[A+1], old);
        cpu_op(1'b0, A + 12'd1, '0, rd, lat);
        chk(rd == 32'hC0FFEE01, "R4 store readback", rd, 32'hC0FFEE01);
        cpu_op(1'b0, A + 12'd0, '0, rd, lat);
        chk(rd == gold[A], "R4 neighbour word intact", rd, gold[A]);
    endtask

    task automatic t_dirty_evict;
        logic [31:0] rd; int lat;
        ev_n = 0;
        cpu_op(1'b0, B, '0, rd, lat);
        chk(ev_n == 8, "R6 transfer count", ev_n, 8);
        for (int k = 0; k < 4; k++) begin
            chk(ev_we[k] && ev_a[k] == A + 12'(k), "R6 write-back order", 32'(ev_a[k]), 32'(A + 12'(k)));
            chk(ev_d[k] == gold[A + 12'(k)], "R6 write-back data", ev_d[k], gold[A + 12'(k)]);
            chk(!ev_we[k+4] && ev_a[k+4] == B + 12'(k), "R6 fill after write-back",
                32'(ev_a[k+4]), 32'(B + 12'(k)));
        end
        chk(rd == gold[B], "R6 read data", rd, gold[B]);
    endtask

    task automatic t_clean_evict;
        logic [31:0] rd; int lat;
        ev_n = 0;
        cpu_op(1'b0, C + 12'd3, '0, rd, lat);
        chk(ev_n == 4, "R7 transfer count", ev_n, 4);
        for (int k = 0; k < 4; k++)
            chk(!ev_we[k] && ev_a[k] == C + 12'(k), "R7 reads only", 32'(ev_a[k]), 32'(C + 12'(k)));
        chk(rd == gold[C+3], "R7 read data", rd, gold[C+3]);
    endtask

    task automatic t_write_miss;
        logic [31:0] rd; int lat;
        mem_lat = 2;
        ev_n = 0;
        cpu_op(1'b1, D + 12'd3, 32'hDEAD0003, rd, lat);
        chk(ev_n == 4, "R5 store miss fetches line", ev_n, 4);
        for (int k = 0; k < 4; k++) begin
            cpu_op(1'b0, D + 12'(k), '0, rd, lat);
            chk(rd == gold[D + 12'(k)], "R5 merged line readback", rd, gold[D + 12'(k)]);
        end
        ev_n = 0;
        cpu_op(1'b0, E, '0, rd, lat);
        chk(ev_n == 8, "R5 eviction transfer count", ev_n, 8);
        for (int k = 0; k < 4; k++)
            chk(bmem[D + 12'(k)] == gold[D + 12'(k)], "R5 written-back line intact",
                bmem[D + 12'(k)], gold[D + 12'(k)]);
        chk(rd == gold[E], "R5 new line data", rd, gold[E]);
    endtask

    task automatic t_write_miss_dirty;
        logic [31:0] rd; int lat;
        mem_lat = 1;
        cpu_op(1'b1, C + 12'd2, 32'h0BADF00D, rd, lat);
        chk(lat == 1, "R4 store hit on refilled line", lat, 1);
        ev_n = 0;
        cpu_op(1'b1, A, 32'h12345678, rd, lat);
        chk(ev_n == 8, "R6 store miss with modified victim", ev_n, 8);
        chk(ev_we[0] && ev_a[0] == C, "R6 first transfer is write-back", 32'(ev_a[0]), 32'(C));
        chk(bmem[C+2] == 32'h0BADF00D, "R6 victim store reached memory", bmem[C+2], 32'h0BADF00D);
        for (int k = 0; k < 4; k++) begin
            cpu_op(1'b0, A + 12'(k), '0, rd, lat);
            chk(rd == gold[A + 12'(k)], "R5 merge over refetched line", rd, gold[A + 12'(k)]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_read();
        t_read_hit();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        t_write_miss_dirty();
        repeat (2) @(negedge clk);
        chk(r8_viol == 0, "R8 ready while memory busy", r8_viol, 0);
        chk(r9_viol == 0, "R9 request changed before ack", r9_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule